// File: doc/BRIEF.md
# Upward-Growing Stack Controller

This block owns an 8-bit stack pointer and a small on-block data RAM, and turns single-cycle push and pop requests into RAM accesses. The pointer always names the most recently filled byte. A push moves the pointer up by one and then stores the byte at that new slot. A pop reads the byte under the pointer and then moves the pointer down by one.

The pointer can also be read and loaded directly through a register-style port, so a processor core can relocate its stack. Leaving reset, the pointer holds 07H, so the first push fills address 08H. Pointer values from 80H upward have no backing storage. Pops there return zero, and pushes there are dropped.

Top module: `upstack_ctrl`

## Requirements
- R1: The pointer is 8 bits wide, can hold any value 00H..FFH, and is always visible on `ptr_rdata`.
- R2: During and right after reset, `ptr_rdata` is 07H and `pop_valid` is 0.
- R3: The first byte pushed after reset is stored at RAM address 08H, so loading 08H and popping returns it.
- R4: A push (`push_req`=1) raises the pointer by one and then writes `push_data` at the raised address.
- R5: A pop (`pop_req`=1) reads the byte at the current pointer and then lowers the pointer by one.
- R6: Pop data appears on `pop_data`, together with a one-cycle `pop_valid`=1, in the cycle after the pop request. `pop_valid` is 0 in every other cycle.
- R7: When push and pop arrive in the same cycle, the push is performed and the pop is ignored: no `pop_valid` and no decrement.
- R8: Pointer arithmetic wraps modulo 256: a push at FFH gives 00H, and a pop at 00H gives FFH.
- R9: At pointer values 80H..FFH a pop returns 00H and a push stores nothing. In particular, a byte held at the low 7-bit alias is left unchanged.
- R10: A load (`ptr_wr`=1) sets the pointer to `ptr_wdata`, visible the next cycle. It overrides a push or pop in the same cycle: no RAM write, no decrement, no `pop_valid`.
- R11: The RAM has 128 bytes at addresses 00H..7FH, all cleared to 00H by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_req | input | 1 | Push request, one-cycle pulse |
| push_data | input | 8 | Byte to push |
| pop_req | input | 1 | Pop request, one-cycle pulse |
| pop_data | output | 8 | Byte returned by the last pop |
| pop_valid | output | 1 | High for one cycle when `pop_data` is new |
| ptr_wr | input | 1 | Load the pointer from `ptr_wdata` |
| ptr_wdata | input | 8 | Value to load into the pointer |
| ptr_rdata | output | 8 | Current pointer value |

## Verification
The bench targets the pointer ends.

- **Wrap at FFH and 00H.** A design that saturates, or that carries into a ninth bit, leaves the pointer wrong after a push at FFH or a pop at 00H.
- **Boundary at 7FH/80H.** A RAM indexed by the low seven bits alone would let a push at 80H overwrite address 00H. A later pop of 00H then exposes this.
- **Request collisions.** Same-cycle push+pop and load+push cases catch a wrong priority, which shows up as a spurious `pop_valid` or an extra pointer step.
- **Pop ordering.** Popping right after a push catches a design that decrements before reading, because it returns the byte below the top.

// File: rtl/upstack_pkg.sv
package upstack_pkg;

    typedef enum logic [1:0] {
        OP_IDLE = 2'd0,
        OP_PUSH = 2'd1,
        OP_POP  = 2'd2,
        OP_LOAD = 2'd3
    } stack_op_e;

endpackage

// File: rtl/upstack_arb.sv
module upstack_arb
    import upstack_pkg::*;
(
    input  logic      push_req,
    input  logic      pop_req,
    input  logic      ptr_wr,
    output stack_op_e op
);
    // Priority: pointer load, then push, then pop.
    always_comb begin
        if (ptr_wr)        op = OP_LOAD;
        else if (push_req) op = OP_PUSH;
        else if (pop_req)  op = OP_POP;
        else               op = OP_IDLE;
    end
endmodule

// File: rtl/upstack_ptr.sv
module upstack_ptr
    import upstack_pkg::*;
#(
    parameter int                 PTR_W     = 8,
    parameter int                 RAM_DEPTH = 128,
    parameter logic [PTR_W-1:0]   RESET_PTR = 8'h07,
    localparam int                AW        = $clog2(RAM_DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  stack_op_e        op,
    input  logic [PTR_W-1:0] load_val,
    output logic [PTR_W-1:0] ptr,
    output logic             wr_en,
    output logic [AW-1:0]    wr_addr,
    output logic [AW-1:0]    rd_addr,
    output logic             rd_ok
);
    localparam logic [PTR_W:0] DEPTH_L = RAM_DEPTH[PTR_W:0];

    typedef struct packed {
        logic [PTR_W-1:0] ptr;
    } ptr_state_t;

    ptr_state_t st_d, st_q;
    logic [PTR_W-1:0] inc_ptr;

    always_comb begin
        st_d    = st_q;
        inc_ptr = st_q.ptr + 1'b1;
        wr_en   = 1'b0;
        wr_addr = inc_ptr[AW-1:0];
        rd_addr = st_q.ptr[AW-1:0];
        rd_ok   = ({1'b0, st_q.ptr} < DEPTH_L);
        unique case (op)
            OP_LOAD: st_d.ptr = load_val;
            OP_PUSH: begin
                st_d.ptr = inc_ptr;
                wr_en    = ({1'b0, inc_ptr} < DEPTH_L);
            end
            OP_POP:  st_d.ptr = st_q.ptr - 1'b1;
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q.ptr <= RESET_PTR;
        else        st_q     <= st_d;
    end

    assign ptr = st_q.ptr;
endmodule

// File: rtl/upstack_ram.sv
module upstack_ram #(
    parameter int  DATA_W    = 8,
    parameter int  RAM_DEPTH = 128,
    localparam int AW        = $clog2(RAM_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem_d [RAM_DEPTH];
    logic [DATA_W-1:0] mem_q [RAM_DEPTH];

    always_comb begin
        mem_d = mem_q;
        if (we) mem_d[waddr] = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < RAM_DEPTH; i++) mem_q[i] <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/upstack_ctrl.sv
module upstack_ctrl
    import upstack_pkg::*;
#(
    parameter int                PTR_W     = 8,
    parameter int                DATA_W    = 8,
    parameter int                RAM_DEPTH = 128,
    parameter logic [PTR_W-1:0]  RESET_PTR = 8'h07
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_req,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop_req,
    output logic [DATA_W-1:0] pop_data,
    output logic              pop_valid,
    input  logic              ptr_wr,
    input  logic [PTR_W-1:0]  ptr_wdata,
    output logic [PTR_W-1:0]  ptr_rdata
);
    localparam int AW = $clog2(RAM_DEPTH);

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              valid;
    } pop_out_t;

    stack_op_e         op;
    logic              wr_en;
    logic [AW-1:0]     wr_addr;
    logic [AW-1:0]     rd_addr;
    logic              rd_ok;
    logic [DATA_W-1:0] rd_data;
    pop_out_t          out_d, out_q;

    upstack_arb arb_i (
        .push_req (push_req),
        .pop_req  (pop_req),
        .ptr_wr   (ptr_wr),
        .op       (op)
    );

    upstack_ptr #(
        .PTR_W     (PTR_W),
        .RAM_DEPTH (RAM_DEPTH),
        .RESET_PTR (RESET_PTR)
    ) ptr_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .op       (op),
        .load_val (ptr_wdata),
        .ptr      (ptr_rdata),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .rd_addr  (rd_addr),
        .rd_ok    (rd_ok)
    );

    upstack_ram #(
        .DATA_W    (DATA_W),
        .RAM_DEPTH (RAM_DEPTH)
    ) ram_i (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_en),
        .waddr (wr_addr),
        .wdata (push_data),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

    always_comb begin
        out_d       = out_q;
        out_d.valid = 1'b0;
        if (op == OP_POP) begin
            out_d.valid = 1'b1;
            out_d.data  = rd_ok ? rd_data : '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign pop_data  = out_q.data;
    assign pop_valid = out_q.valid;
endmodule

// File: rtl/upstack_ctrl_chk.sv
module upstack_ctrl_chk #(
    parameter int PTR_W     = 8,
    parameter int DATA_W    = 8,
    parameter int RAM_DEPTH = 128
) (
    input logic              clk,
    input logic              rst_n,
    input logic              push_req,
    input logic              pop_req,
    input logic              ptr_wr,
    input logic [PTR_W-1:0]  ptr_wdata,
    input logic [PTR_W-1:0]  ptr_rdata,
    input logic [DATA_W-1:0] pop_data,
    input logic              pop_valid
);
    localparam logic [PTR_W:0] DEPTH_L = RAM_DEPTH[PTR_W:0];

    logic pop_acc;
    assign pop_acc = pop_req && !push_req && !ptr_wr;

    // R4, R8
    assert_push_inc_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && !ptr_wr) |=> (ptr_rdata == PTR_W'($past(ptr_rdata) + 1'b1)));

    // R5, R8
    assert_pop_dec_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pop_acc |=> (ptr_rdata == PTR_W'($past(ptr_rdata) - 1'b1)));

    assert_pop_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pop_acc |=> pop_valid);

    // R7, R10
    assert_no_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !pop_acc |=> !pop_valid);

    assert_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_wr |=> (ptr_rdata == $past(ptr_wdata)));

    assert_idle_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!push_req && !pop_req && !ptr_wr) |=> $stable(ptr_rdata));

    assert_oor_pop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_acc && ({1'b0, ptr_rdata} >= DEPTH_L)) |=> (pop_data == '0));
endmodule

bind upstack_ctrl upstack_ctrl_chk #(
    .PTR_W     (PTR_W),
    .DATA_W    (DATA_W),
    .RAM_DEPTH (RAM_DEPTH)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_req  (push_req),
    .pop_req   (pop_req),
    .ptr_wr    (ptr_wr),
    .ptr_wdata (ptr_wdata),
    .ptr_rdata (ptr_rdata),
    .pop_data  (pop_data),
    .pop_valid (pop_valid)
);

// File: tb/upstack_ctrl_tb_top.sv
module upstack_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       push_req = 1'b0;
    logic [7:0] push_data = '0;
    logic       pop_req = 1'b0;
    logic [7:0] pop_data;
    logic       pop_valid;
    logic       ptr_wr = 1'b0;
    logic [7:0] ptr_wdata = '0;
    logic [7:0] ptr_rdata;

    int checks = 0;
    int errors = 0;
    logic [7:0] m_mem [128];
    logic [7:0] m_ptr;

    always #4 clk = ~clk;

    upstack_ctrl dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_req  (push_req),
        .push_data (push_data),
        .pop_req   (pop_req),
        .pop_data  (pop_data),
        .pop_valid (pop_valid),
        .ptr_wr    (ptr_wr),
        .ptr_wdata (ptr_wdata),
        .ptr_rdata (ptr_rdata)
    );

    function automatic logic in_ram(input logic [7:0] a);
        return a < 8'd128;
    endfunction

    function automatic logic [7:0] exp_pop_byte(input logic [7:0] a);
        return in_ram(a) ? m_mem[a[6:0]] : 8'h00;
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic cyc(input bit pu, input logic [7:0] pd, input bit po,
                       input bit wr, input logic [7:0] wd, input string tag);
        logic       e_valid;
        logic [7:0] e_data;
        @(negedge clk);
        push_req = pu; push_data = pd; pop_req = po; ptr_wr = wr; ptr_wdata = wd;
        e_valid = 1'b0;
        e_data  = 8'h00;
        if (wr) m_ptr = wd;
        else if (pu) begin
            m_ptr = m_ptr + 8'd1;
            if (in_ram(m_ptr)) m_mem[m_ptr[6:0]] = pd;
        end else if (po) begin
            e_valid = 1'b1;
            e_data  = exp_pop_byte(m_ptr);
            m_ptr   = m_ptr - 8'd1;
        end
        @(posedge clk);
        #1;
        check({tag, " ptr"}, ptr_rdata, m_ptr);
        check({tag, " R6 valid"}, {7'd0, pop_valid}, {7'd0, e_valid});
        if (e_valid) check({tag, " data"}, pop_data, e_data);
    endtask

    initial begin
        #(200000 * 8);
        errors++;
        $display("FAIL watchdog expired actual running expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd24601));
        for (int i = 0; i < 128; i++) m_mem[i] = 8'h00;
        m_ptr = 8'h07;
        repeat (3) @(posedge clk);
        #1;
        check("R2 ptr in reset", ptr_rdata, 8'h07);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check("R2 ptr after reset", ptr_rdata, 8'h07);
        check("R2 valid after reset", {7'd0, pop_valid}, 8'h00);

        cyc(1, 8'hA5, 0, 0, 8'h00, "R3 R4 first push");
        cyc(0, 8'h00, 1, 0, 8'h00, "R5 pop top");
        cyc(0, 8'h00, 0, 1, 8'h08, "R10 load 08");
        cyc(0, 8'h00, 1, 0, 8'h00, "R3 pop at 08");
        cyc(1, 8'h3C, 1, 0, 8'h00, "R7 push and pop");
        cyc(0, 8'h00, 1, 0, 8'h00, "R7 pop after collision");
        cyc(1, 8'h99, 0, 1, 8'h20, "R10 load over push");
        cyc(0, 8'h00, 1, 1, 8'h08, "R10 load over pop");
        cyc(0, 8'h00, 1, 0, 8'h00, "R10 slot untouched");
        cyc(0, 8'h00, 0, 1, 8'hFF, "R1 load FF");
        cyc(1, 8'h11, 0, 0, 8'h00, "R8 push wrap");
        cyc(0, 8'h00, 1, 0, 8'h00, "R8 pop at 00");
        cyc(0, 8'h00, 1, 0, 8'h00, "R9 pop at FF");
        cyc(0, 8'h00, 0, 1, 8'h00, "R8 load 00");
        cyc(1, 8'h22, 0, 0, 8'h00, "R8 push to 01");
        cyc(0, 8'h00, 0, 1, 8'h7F, "R9 load 7F");
        cyc(1, 8'h77, 0, 0, 8'h00, "R9 push to 80");
        cyc(0, 8'h00, 1, 0, 8'h00, "R9 pop at 80");
        cyc(0, 8'h00, 0, 1, 8'h00, "R9 load 00");
        cyc(0, 8'h00, 1, 0, 8'h00, "R9 alias untouched");
        cyc(0, 8'h00, 0, 1, 8'h50, "R11 load 50");
        cyc(0, 8'h00, 1, 0, 8'h00, "R11 cleared byte");
        cyc(0, 8'h00, 0, 1, 8'hC3, "R1 load C3");
        cyc(0, 8'h00, 0, 0, 8'h00, "R1 idle hold");

        for (int n = 0; n < 4000; n++) begin
            int unsigned r;
            r = $urandom_range(0, 99);
            if (r < 4)
                cyc(0, 8'h00, 0, 1, 8'($urandom_range(0, 8'h90)), "R10 rnd load");
            else if (r < 8)
                cyc(1, 8'($urandom), 1, 0, 8'h00, "R7 rnd both");
            else if (r < 50)
                cyc(1, 8'($urandom), 0, 0, 8'h00, "R4 rnd push");
            else if (r < 92)
                cyc(0, 8'h00, 1, 0, 8'h00, "R5 rnd pop");
            else
                cyc(0, 8'h00, 0, 0, 8'h00, "R1 rnd idle");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule